// File: doc/BRIEF.md
# Host Adapter Interrupt and Status Register Unit

This unit keeps the three byte-wide registers a bus host adapter exposes for interrupt handling: the interrupt-cause register, the status register and the sequence-step register. It also drives a level interrupt line toward the host. Other logic in the adapter posts events here. A generic event carries a cause code and a sequence step. A control strobe carries one of three bus/selection operations. A completion strobe carries the target's status byte. The host acknowledges an interrupt by reading the cause register, and that read clears the pending state.

The unit never drops a completion. A completion that arrives while an earlier interrupt is still unacknowledged is not reported over it. Its status byte is parked in a one-entry slot. When the host later reads the cause register, the parked completion is reported as a fresh interrupt in the same cycle. The unit also holds a configuration byte and a transfer counter, because completion reporting and bus-reset reporting depend on or modify them.

Status register layout: bit 7 is the interrupt flag, bit 4 is the count-zero bit, and bits 2:0 are the bus phase (3 means status phase). All other bits read 0.

Top module: `hbi_irq_ctrl`

## Requirements
- R1: A synchronous reset clears the cause, status, sequence, counter and status-byte registers, drops the interrupt line and discards any parked completion within one cycle. The configuration byte resets to 0x07.
- R2: A generic event loads the cause register with its code and the sequence register with its step. It sets status bit 7 and asserts the interrupt line on the next cycle. The interrupt line always equals status bit 7.
- R3: A raise while status bit 7 is already set leaves the flag and the line asserted; only the cause and step fields take the new values.
- R4: A host read of the cause register, with no other event in that cycle and nothing parked, gives the following on the next cycle: cause 0x00, status bits 7 and 4 clear, sequence step 4, and the interrupt line low. The phase bits are kept.
- R5: A completion that arrives while status bit 7 is set changes no visible register. Its status byte is parked.
- R6: A host read while a completion is parked reports that parked completion in the same cycle. The status-byte output shows the parked byte, and the interrupt is raised again.
- R7: Reporting a completion works as follows. The cause register becomes bus-service 0x10, the status register becomes 0x93 (flag, count-zero, status phase), the sequence step becomes 0, the transfer counter becomes 0, and the status byte is latched.
- R8: The bus-reset operation (code 0) loads cause 0x80. It raises the interrupt only when configuration bit 6 is clear.
- R9: The selection-disable operation (code 1) clears the cause register and raises the interrupt. The selection-enable operation (code 2) clears the cause register and does not raise it.
- R10: When a host read and a raise occur in the same cycle, the raise wins. The new cause is held and the flag and line stay set.
- R11: A counter write loads the transfer counter and clears status bit 4. A configuration write loads the configuration byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| rd_intr_i | input | 1 | Host read strobe of the cause register |
| ev_valid_i | input | 1 | Generic interrupt event strobe |
| ev_cause_i | input | 8 | Cause code for the event |
| ev_seq_i | input | 3 | Sequence step for the event |
| cmd_valid_i | input | 1 | Control operation strobe |
| cmd_op_i | input | 2 | 0 bus reset, 1 selection disable, 2 selection enable |
| cpl_valid_i | input | 1 | Command-completion strobe |
| cpl_status_i | input | 8 | Target status byte of the completion |
| cfg1_wr_i | input | 1 | Configuration byte write strobe |
| cfg1_wdata_i | input | 8 | Configuration byte write data |
| cnt_wr_i | input | 1 | Transfer counter write strobe |
| cnt_wdata_i | input | CNT_W | Transfer counter write data |
| irq_o | output | 1 | Level interrupt line |
| intr_o | output | 8 | Cause register |
| stat_o | output | 8 | Status register |
| seq_o | output | 3 | Sequence-step register |
| cfg1_o | output | 8 | Configuration byte |
| cnt_o | output | CNT_W | Transfer counter |
| cpl_status_o | output | 8 | Last reported completion status byte |

## Verification
The hardest state to reach is a parked completion. It only exists when a completion lands on an unacknowledged interrupt, and it is visible at the ports only after the next host read replays it. The stimulus first reports one completion directly. It then sends a second completion with a different status byte while that interrupt is still pending, and checks that no register moved. Finally it reads the cause register and checks that the second byte appears together with a fresh interrupt. A separate sequence parks a completion and then resets. A read after the reset must produce no replay.

// File: rtl/hbi_irq_pkg.sv
package hbi_irq_pkg;
   localparam int REG_W = 8;
   localparam int SEQ_W = 3;

   localparam int STAT_FLAG_BIT = 7;
   localparam int STAT_TC_BIT   = 4;

   localparam logic [REG_W-1:0] CAUSE_BUS_SVC = 8'h10;
   localparam logic [REG_W-1:0] CAUSE_BUS_RST = 8'h80;

   localparam logic [2:0]       PHASE_STATUS  = 3'd3;
   localparam logic [SEQ_W-1:0] SEQ_DONE      = 3'd4;

   typedef enum logic [1:0] {
      OP_BUS_RESET   = 2'd0,
      OP_SEL_DISABLE = 2'd1,
      OP_SEL_ENABLE  = 2'd2,
      OP_NONE        = 2'd3
   } ctl_op_e;
endpackage

// File: rtl/hbi_defer_slot.sv
module hbi_defer_slot #(
   parameter int DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              capture_i,
   input  logic [DATA_W-1:0] data_i,
   input  logic              release_i,
   output logic              pend_o,
   output logic [DATA_W-1:0] data_o
);
   logic              pend_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         pend_q <= 1'b0;
         data_q <= '0;
      end else begin
         if (capture_i) begin
            pend_q <= 1'b1;
            data_q <= data_i;
         end else if (release_i) begin
            pend_q <= 1'b0;
         end
      end
   end

   assign pend_o = pend_q;
   assign data_o = data_q;

   // a replay may only draw on a slot that actually holds a completion
   assert_release_needs_pend_R6: assert property (@(posedge clk_i) disable iff (rst_i)
      release_i |-> pend_q);
   assert_capture_parks_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      capture_i |=> (pend_q && data_q == $past(data_i)));
endmodule

// File: rtl/hbi_cnt_reg.sv
module hbi_cnt_reg #(
   parameter int CNT_W = 24
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             load_i,
   input  logic [CNT_W-1:0] data_i,
   input  logic             clr_i,
   output logic [CNT_W-1:0] cnt_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)       cnt_q <= '0;
      else if (clr_i)  cnt_q <= '0;
      else if (load_i) cnt_q <= data_i;
   end

   assign cnt_o = cnt_q;

   assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      clr_i |=> (cnt_q == '0));
   assert_load_takes_R11: assert property (@(posedge clk_i) disable iff (rst_i)
      (load_i && !clr_i) |=> (cnt_q == $past(data_i)));
endmodule

// File: rtl/hbi_irq_line.sv
module hbi_irq_line #(
   parameter bit ACTIVE_LOW = 1'b0
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic raise_i,
   input  logic drop_i,
   output logic level_o,
   output logic irq_o
);
   logic level_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)        level_q <= 1'b0;
      else if (raise_i) level_q <= 1'b1;
      else if (drop_i)  level_q <= 1'b0;
   end

   assign level_o = level_q;

   generate
      if (ACTIVE_LOW) begin : g_pol_low
         assign irq_o = ~level_q;
      end else begin : g_pol_high
         assign irq_o = level_q;
      end
   endgenerate

   assert_raise_wins_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      raise_i |=> level_q);
endmodule

// File: rtl/hbi_irq_ctrl.sv
module hbi_irq_ctrl
   import hbi_irq_pkg::*;
#(
   parameter int         CNT_W        = 24,
   parameter int         RST_RPT_BIT  = 6,
   parameter logic [7:0] CFG1_RST_VAL = 8'h07,
   parameter bit         IRQ_ACTIVE_LOW = 1'b0
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             rd_intr_i,
   input  logic             ev_valid_i,
   input  logic [7:0]       ev_cause_i,
   input  logic [2:0]       ev_seq_i,
   input  logic             cmd_valid_i,
   input  logic [1:0]       cmd_op_i,
   input  logic             cpl_valid_i,
   input  logic [7:0]       cpl_status_i,
   input  logic             cfg1_wr_i,
   input  logic [7:0]       cfg1_wdata_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] cnt_wdata_i,
   output logic             irq_o,
   output logic [7:0]       intr_o,
   output logic [7:0]       stat_o,
   output logic [2:0]       seq_o,
   output logic [7:0]       cfg1_o,
   output logic [CNT_W-1:0] cnt_o,
   output logic [7:0]       cpl_status_o
);
   generate
      if (CNT_W < 1 || CNT_W > 32) begin : g_bad_cnt_w
         $error("hbi_irq_ctrl: CNT_W out of range");
      end
      if (RST_RPT_BIT < 0 || RST_RPT_BIT >= REG_W) begin : g_bad_rpt_bit
         $error("hbi_irq_ctrl: RST_RPT_BIT outside the configuration byte");
      end
   endgenerate

   logic [REG_W-1:0] intr_q, intr_n;
   logic [REG_W-1:0] stat_q, stat_n;
   logic [SEQ_W-1:0] seq_q,  seq_n;
   logic [REG_W-1:0] cfg1_q, sbyte_q, sbyte_n;

   logic raise, drop, rep_defer, rep_cpl, cap, cnt_clr;
   logic pend;
   logic [REG_W-1:0] pend_data;
   logic irq_lvl;

   always_comb begin
      intr_n    = intr_q;
      stat_n    = stat_q;
      seq_n     = seq_q;
      sbyte_n   = sbyte_q;
      raise     = 1'b0;
      drop      = 1'b0;
      cnt_clr   = 1'b0;

      if (cnt_wr_i) stat_n[STAT_TC_BIT] = 1'b0;

      if (rd_intr_i) begin
         intr_n                = '0;
         stat_n[STAT_TC_BIT]   = 1'b0;
         stat_n[STAT_FLAG_BIT] = 1'b0;
         seq_n                 = SEQ_DONE;
         drop                  = 1'b1;
      end

      if (cmd_valid_i) begin
         case (ctl_op_e'(cmd_op_i))
            OP_BUS_RESET: begin
               intr_n = CAUSE_BUS_RST;
               if (!cfg1_q[RST_RPT_BIT]) raise = 1'b1;
            end
            OP_SEL_DISABLE: begin
               intr_n = '0;
               raise  = 1'b1;
            end
            OP_SEL_ENABLE: intr_n = '0;
            default: ;
         endcase
      end

      if (ev_valid_i) begin
         intr_n = ev_cause_i;
         seq_n  = ev_seq_i;
         raise  = 1'b1;
      end

      if (raise) stat_n[STAT_FLAG_BIT] = 1'b1;

      rep_defer = rd_intr_i && pend && !stat_n[STAT_FLAG_BIT];
      rep_cpl   = cpl_valid_i && !stat_n[STAT_FLAG_BIT] && !rep_defer;
      cap       = cpl_valid_i && !rep_cpl;

      if (rep_defer || rep_cpl) begin
         stat_n                = '0;
         stat_n[2:0]           = PHASE_STATUS;
         stat_n[STAT_TC_BIT]   = 1'b1;
         stat_n[STAT_FLAG_BIT] = 1'b1;
         intr_n                = CAUSE_BUS_SVC;
         seq_n                 = '0;
         cnt_clr               = 1'b1;
         sbyte_n               = rep_defer ? pend_data : cpl_status_i;
         raise                 = 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         intr_q  <= '0;
         stat_q  <= '0;
         seq_q   <= '0;
         sbyte_q <= '0;
         cfg1_q  <= CFG1_RST_VAL;
      end else begin
         intr_q  <= intr_n;
         stat_q  <= stat_n;
         seq_q   <= seq_n;
         sbyte_q <= sbyte_n;
         if (cfg1_wr_i) cfg1_q <= cfg1_wdata_i;
      end
   end

   hbi_defer_slot #(.DATA_W(REG_W)) u_defer (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .capture_i (cap),
      .data_i    (cpl_status_i),
      .release_i (rep_defer),
      .pend_o    (pend),
      .data_o    (pend_data)
   );

   hbi_cnt_reg #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_i  (rst_i),
      .load_i (cnt_wr_i),
      .data_i (cnt_wdata_i),
      .clr_i  (cnt_clr),
      .cnt_o  (cnt_o)
   );

   hbi_irq_line #(.ACTIVE_LOW(IRQ_ACTIVE_LOW)) u_line (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .raise_i (raise),
      .drop_i  (drop),
      .level_o (irq_lvl),
      .irq_o   (irq_o)
   );

   assign intr_o       = intr_q;
   assign stat_o       = stat_q;
   assign seq_o        = seq_q;
   assign cfg1_o       = cfg1_q;
   assign cpl_status_o = sbyte_q;

   // line flop and status flag live in different registers; they must agree
   assert_line_tracks_flag_R2: assert property (@(posedge clk_i) disable iff (rst_i)
      irq_lvl == stat_q[STAT_FLAG_BIT]);
   assert_flag_sticky_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      (stat_q[STAT_FLAG_BIT] && !rd_intr_i) |=> stat_q[STAT_FLAG_BIT]);
   assert_read_clears_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_intr_i && !ev_valid_i && !cmd_valid_i && !cpl_valid_i && !pend)
      |=> (intr_q == '0 && !stat_q[STAT_FLAG_BIT] && seq_q == SEQ_DONE));
   assert_hold_while_pending_R5: assert property (@(posedge clk_i) disable iff (rst_i)
      (stat_q[STAT_FLAG_BIT] && cpl_valid_i && !rd_intr_i && !ev_valid_i &&
       !cmd_valid_i && !cnt_wr_i)
      |=> ($stable(intr_q) && $stable(stat_q) && $stable(seq_q) && pend));
   assert_rpt_disable_R8: assert property (@(posedge clk_i) disable iff (rst_i)
      (cmd_valid_i && cmd_op_i == 2'd0 && cfg1_q[RST_RPT_BIT] &&
       !stat_q[STAT_FLAG_BIT] && !ev_valid_i && !cpl_valid_i && !rd_intr_i)
      |=> !stat_q[STAT_FLAG_BIT]);
   assert_read_raise_same_cycle_R10: assert property (@(posedge clk_i) disable iff (rst_i)
      (rd_intr_i && ev_valid_i && !cpl_valid_i && !pend)
      |=> (stat_q[STAT_FLAG_BIT] && intr_q == $past(ev_cause_i)));
endmodule

// File: tb/hbi_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module hbi_irq_ctrl_tb_top;
   localparam int CNT_W = 24;

   logic             clk = 1'b0;
   logic             rst_i;
   logic             rd_intr_i, ev_valid_i, cmd_valid_i, cpl_valid_i;
   logic             cfg1_wr_i, cnt_wr_i;
   logic [7:0]       ev_cause_i, cpl_status_i, cfg1_wdata_i;
   logic [2:0]       ev_seq_i;
   logic [1:0]       cmd_op_i;
   logic [CNT_W-1:0] cnt_wdata_i;
   logic             irq_o;
   logic [7:0]       intr_o, stat_o, cfg1_o, cpl_status_o;
   logic [2:0]       seq_o;
   logic [CNT_W-1:0] cnt_o;

   always #10 clk = ~clk;

   hbi_irq_ctrl #(.CNT_W(CNT_W)) dut_i (
      .clk_i(clk), .rst_i(rst_i), .rd_intr_i(rd_intr_i),
      .ev_valid_i(ev_valid_i), .ev_cause_i(ev_cause_i), .ev_seq_i(ev_seq_i),
      .cmd_valid_i(cmd_valid_i), .cmd_op_i(cmd_op_i),
      .cpl_valid_i(cpl_valid_i), .cpl_status_i(cpl_status_i),
      .cfg1_wr_i(cfg1_wr_i), .cfg1_wdata_i(cfg1_wdata_i),
      .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
      .irq_o(irq_o), .intr_o(intr_o), .stat_o(stat_o), .seq_o(seq_o),
      .cfg1_o(cfg1_o), .cnt_o(cnt_o), .cpl_status_o(cpl_status_o)
   );

   typedef struct packed {
      logic [7:0]       intr;
      logic [7:0]       stat;
      logic [2:0]       seq;
      logic             irq;
      logic [CNT_W-1:0] cnt;
      logic [7:0]       sb;
      logic [7:0]       cfg;
   } snap_t;

   snap_t exp_q[$];
   string req_q[$];
   event  chk_ev;
   int    tests = 0;
   int    fails = 0;
   bit    done  = 0;

   function automatic snap_t mk(logic [7:0] intr, logic [7:0] stat, logic [2:0] seq,
                                logic irq, logic [CNT_W-1:0] cnt, logic [7:0] sb,
                                logic [7:0] cfg);
      snap_t s;
      s.intr = intr; s.stat = stat; s.seq = seq; s.irq = irq;
      s.cnt = cnt; s.sb = sb; s.cfg = cfg;
      return s;
   endfunction

   // monitor: pops expected snapshots and compares with the ports
   initial begin
      forever begin
         @(chk_ev);
         while (exp_q.size() > 0) begin
            snap_t e, a;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            a = mk(intr_o, stat_o, seq_o, irq_o, cnt_o, cpl_status_o, cfg1_o);
            tests++;
            if (a !== e) begin
               fails++;
               $display("FAIL %s: actual intr=%h stat=%h seq=%0d irq=%b cnt=%h sb=%h cfg=%h expected intr=%h stat=%h seq=%0d irq=%b cnt=%h sb=%h cfg=%h",
                        r, a.intr, a.stat, a.seq, a.irq, a.cnt, a.sb, a.cfg,
                        e.intr, e.stat, e.seq, e.irq, e.cnt, e.sb, e.cfg);
            end
         end
      end
   end

   task automatic clear_strobes();
      rst_i = 1'b0; rd_intr_i = 1'b0; ev_valid_i = 1'b0; cmd_valid_i = 1'b0;
      cpl_valid_i = 1'b0; cfg1_wr_i = 1'b0; cnt_wr_i = 1'b0;
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
      clear_strobes();
   endtask

   task automatic expect_now(snap_t s, string r);
      exp_q.push_back(s);
      req_q.push_back(r);
      -> chk_ev;
   endtask

   task automatic do_ev(logic [7:0] c, logic [2:0] sq);
      ev_valid_i = 1'b1; ev_cause_i = c; ev_seq_i = sq;
   endtask

   task automatic do_cmd(logic [1:0] op);
      cmd_valid_i = 1'b1; cmd_op_i = op;
   endtask

   task automatic do_cpl(logic [7:0] st);
      cpl_valid_i = 1'b1; cpl_status_i = st;
   endtask

   // watchdog
   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         tests++; fails++;
         $display("FAIL R1: watchdog expired actual=hung expected=finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      clear_strobes();
      ev_cause_i = '0; ev_seq_i = '0; cmd_op_i = 2'd3; cpl_status_i = '0;
      cfg1_wdata_i = '0; cnt_wdata_i = '0;
      rst_i = 1'b1;
      repeat (2) @(negedge clk);
      rst_i = 1'b0;
      expect_now(mk(8'h00, 8'h00, 3'd0, 1'b0, 24'h0, 8'h00, 8'h07), "R1 reset state");

      cnt_wr_i = 1'b1; cnt_wdata_i = 24'h000123; tick();
      expect_now(mk(8'h00, 8'h00, 3'd0, 1'b0, 24'h000123, 8'h00, 8'h07), "R11 counter load");

      do_ev(8'h08, 3'd2); tick();
      expect_now(mk(8'h08, 8'h80, 3'd2, 1'b1, 24'h000123, 8'h00, 8'h07), "R2 event raise");

      do_ev(8'h18, 3'd4); tick();
      expect_now(mk(8'h18, 8'h80, 3'd4, 1'b1, 24'h000123, 8'h00, 8'h07), "R3 repeated raise");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h00, 3'd4, 1'b0, 24'h000123, 8'h00, 8'h07), "R4 read clears");

      do_cpl(8'h02); tick();
      expect_now(mk(8'h10, 8'h93, 3'd0, 1'b1, 24'h0, 8'h02, 8'h07), "R7 direct completion");

      do_cpl(8'h55); tick();
      expect_now(mk(8'h10, 8'h93, 3'd0, 1'b1, 24'h0, 8'h02, 8'h07), "R5 completion parked");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h10, 8'h93, 3'd0, 1'b1, 24'h0, 8'h55, 8'h07), "R6 parked replay");

      cnt_wr_i = 1'b1; cnt_wdata_i = 24'h000010; tick();
      expect_now(mk(8'h10, 8'h83, 3'd0, 1'b1, 24'h000010, 8'h55, 8'h07), "R11 counter write clears count-zero");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h000010, 8'h55, 8'h07), "R4 read keeps phase");

      cnt_wr_i = 1'b1; cnt_wdata_i = 24'h0ABCDE; tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h07), "R11 counter reload");

      do_cmd(2'd0); tick();
      expect_now(mk(8'h80, 8'h83, 3'd4, 1'b1, 24'h0ABCDE, 8'h55, 8'h07), "R8 bus reset reported");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h07), "R4 read after bus reset");

      cfg1_wr_i = 1'b1; cfg1_wdata_i = 8'h47; tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h47), "R11 config write");

      do_cmd(2'd0); tick();
      expect_now(mk(8'h80, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h47), "R8 bus reset silent");

      do_cmd(2'd2); tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h47), "R9 selection enable");

      do_cmd(2'd1); tick();
      expect_now(mk(8'h00, 8'h83, 3'd4, 1'b1, 24'h0ABCDE, 8'h55, 8'h47), "R9 selection disable");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h47), "R4 read");

      do_ev(8'h08, 3'd2); tick();
      expect_now(mk(8'h08, 8'h83, 3'd2, 1'b1, 24'h0ABCDE, 8'h55, 8'h47), "R2 event raise");

      rd_intr_i = 1'b1; do_ev(8'h20, 3'd1); tick();
      expect_now(mk(8'h20, 8'h83, 3'd1, 1'b1, 24'h0ABCDE, 8'h55, 8'h47), "R10 read and raise together");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h03, 3'd4, 1'b0, 24'h0ABCDE, 8'h55, 8'h47), "R4 read after R10");

      do_cpl(8'hAA); tick();
      expect_now(mk(8'h10, 8'h93, 3'd0, 1'b1, 24'h0, 8'hAA, 8'h47), "R7 completion clears counter");

      do_cpl(8'h66); tick();
      expect_now(mk(8'h10, 8'h93, 3'd0, 1'b1, 24'h0, 8'hAA, 8'h47), "R5 second park");

      rst_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h00, 3'd0, 1'b0, 24'h0, 8'h00, 8'h07), "R1 reset mid-run");

      rd_intr_i = 1'b1; tick();
      expect_now(mk(8'h00, 8'h00, 3'd4, 1'b0, 24'h0, 8'h00, 8'h07), "R1 parked completion discarded");

      @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule